// File: doc/BRIEF.md
# Modulo Overflow Timer

This block is a free-running up-counter that divides its clock through a power-of-two prescaler and wraps back to zero each time it has reached a modulo value supplied on a dedicated input port. The wrap raises a sticky overflow flag. An interrupt line is driven from that flag, qualified by an enable bit. Software controls the block through a small synchronous register bus. One 8-bit control/status byte holds the flag, the enable, a halt bit, a one-shot counter-clear bit and the prescaler select. Two further addresses return the live count.

The flag can only be cleared by a handshake. Software reads the status byte while the flag is set, then writes 0 to the flag bit. If another wrap happens between the read and the write, the write does nothing, so no wrap event is lost. The block comes out of reset halted, and software starts it by clearing the halt bit.

Top module: `ovf_timer`

## Requirements
- R1: After reset the status byte reads 0x20 (halted, flag 0, enable 0, prescaler select 0), the count reads 0 and `irq` is 0.
- R2: While the halt bit (status bit 5) is 1, neither the count nor the prescaler moves. Once it is 0, counting resumes from the held value.
- R3: With prescaler select S (status bits 2..0), the count advances once per 2^S running clock cycles. After n running cycles from a cleared state, the count is floor(n / 2^S).
- R4: On a prescaler step where the count equals `mod_val`, the count becomes 0 and the overflow flag (status bit 7) is set.
- R5: A status read taken while the flag is 1 arms the clear. A following status write with bit 7 = 0 then clears the flag.
- R6: A status write with bit 7 = 0 that is not preceded by an arming read leaves the flag set.
- R7: An overflow that occurs after the arming read and before the write disarms the clear, so the write leaves the flag set.
- R8: Writing 1 to status bit 7 never sets the flag.
- R9: A status write with bit 4 = 1 zeroes the count and the prescaler in that cycle. Bit 4 always reads 0. Bits 6, 5 and 2..0 take the written values as in any status write, and the flag is not changed.
- R10: A status write with both bit 5 and bit 4 set leaves the count held at 0.
- R11: `irq` equals the flag ANDed with the enable bit (status bit 6), one clock cycle later.
- R12: Register map: address 0 is the status byte, with bit 3 always reading 0. Address 1 is count bits 15..8 and address 2 is count bits 7..0, zero-extended. Address 3 reads 0. `rdata` is updated on the clock edge that samples `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mod_val | input | CNT_W | Modulo value at which the count wraps |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the timer with an 8-bit counter, so that a full-range modulo of 0xFF and every prescaler select up to 128 can be run within a few hundred cycles each. It chooses run lengths one cycle short of a prescaler boundary. A small modulo of 3 or 5, or 0, makes wraps occur at predictable edges. This lets the bench place an overflow exactly between the arming read and the clearing write, or keep one away from it.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int PS_W   = 3;
  localparam int PSC_W  = (1 << PS_W) - 1;
  localparam int DATA_W = 8;

  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int HALT_B = 5;
  localparam int CLR_B  = 4;

  localparam int A_STAT = 0;
  localparam int A_CNTH = 1;
  localparam int A_CNTL = 2;

  localparam logic [DATA_W-1:0] STAT_RST = 8'h20;

  // low S bits of the prescaler that must all be ones for a step
  function automatic logic [PSC_W-1:0] psc_mask(input logic [PS_W-1:0] sel);
    psc_mask = PSC_W'((32'd1 << sel) - 32'd1);
  endfunction

  function automatic logic step_due(input logic [PSC_W-1:0] psc,
                                    input logic [PS_W-1:0]  sel);
    step_due = ((psc & psc_mask(sel)) == psc_mask(sel));
  endfunction
endpackage

// File: rtl/ovf_timer_psc.sv
module ovf_timer_psc
  import ovf_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            step
);
  logic [PSC_W-1:0] psc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (run) psc_q <= psc_q + 1'b1;
  end

  assign step = run && !clr && step_due(psc_q, sel);
endmodule

// File: rtl/ovf_timer_cnt.sv
module ovf_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_mod;

  assign at_mod = (cnt == mod_val);
  assign wrap   = step && at_mod && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= at_mod ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ovf_timer_regs.sv
module ovf_timer_regs
  import ovf_timer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [15:0]       cnt16,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output logic              flag_q,
  output logic              armed_q,
  output logic              ie_q,
  output logic              halt_q,
  output logic [PS_W-1:0]   sel_q,
  output logic              clr_pulse,
  output logic              irq_q
);
  logic stat_wr, stat_rd, clear_ok;

  assign stat_wr   = wr_en && (addr == ADDR_W'(A_STAT));
  assign stat_rd   = rd_en && (addr == ADDR_W'(A_STAT));
  assign clr_pulse = stat_wr && wdata[CLR_B];
  assign clear_ok  = stat_wr && !wdata[FLAG_B] && armed_q && !wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap)          flag_q <= 1'b1;
      else if (clear_ok) flag_q <= 1'b0;

      if (wrap || clear_ok)     armed_q <= 1'b0;
      else if (stat_rd && flag_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= STAT_RST[IE_B];
      halt_q <= STAT_RST[HALT_B];
      sel_q  <= STAT_RST[PS_W-1:0];
    end else if (stat_wr) begin
      ie_q   <= wdata[IE_B];
      halt_q <= wdata[HALT_B];
      sel_q  <= wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= flag_q && ie_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADDR_W'(A_STAT): rdata <= {flag_q, ie_q, halt_q, 2'b00, sel_q};
        ADDR_W'(A_CNTH): rdata <= cnt16[15:8];
        ADDR_W'(A_CNTL): rdata <= cnt16[7:0];
        default:         rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  mod_val,
  output logic              irq
);
  logic             step, wrap_evt, clr_pulse;
  logic             flag_q, armed_q, ie_q, halt_q;
  logic [PS_W-1:0]  sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cnt16;

  assign cnt16 = 16'(cnt_q);

  ovf_timer_psc u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!halt_q),
    .clr  (clr_pulse),
    .sel  (sel_q),
    .step (step)
  );

  ovf_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .step   (step),
    .mod_val(mod_val),
    .cnt    (cnt_q),
    .wrap   (wrap_evt)
  );

  ovf_timer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt16    (cnt16),
    .wrap     (wrap_evt),
    .rdata    (rdata),
    .flag_q   (flag_q),
    .armed_q  (armed_q),
    .ie_q     (ie_q),
    .halt_q   (halt_q),
    .sel_q    (sel_q),
    .clr_pulse(clr_pulse),
    .irq_q    (irq)
  );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wrap_evt,
  input logic              clr_pulse,
  input logic              flag_q,
  input logic              armed_q,
  input logic              ie_q,
  input logic              halt_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              irq
);
  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0));

  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(armed_q) && $past(wr_en) &&
                       ($past(addr) == '0) && !$past(wdata[7])));

  // R7
  wrap_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !armed_q);

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !clr_pulse) |=> $stable(cnt_q));

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_q == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(flag_q && ie_q));
endmodule

bind ovf_timer ovf_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .wrap_evt (wrap_evt),
  .clr_pulse(clr_pulse),
  .flag_q   (flag_q),
  .armed_q  (armed_q),
  .ie_q     (ie_q),
  .halt_q   (halt_q),
  .cnt_q    (cnt_q),
  .irq      (irq)
);

// File: tb/sim_ovf_timer.sv
`timescale 1ns/1ps
module sim_ovf_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [CW-1:0] mod_val = 8'hFF;
  logic          irq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  ovf_timer #(.CNT_W(CW), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mod_val(mod_val), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the latching edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n counted edges from a zeroed state, halted afterwards
  task automatic run_from_zero(input logic [2:0] sel, input int n);
    wr(2'd0, 8'h30);
    wr(2'd0, {5'b0, sel});
    idle(n - 1);
    wr(2'd0, {5'b00100, sel});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 status after reset", d, 8'h20);
    rd(2'd2, d); chk("R1 count after reset", d, 0);
    chk("R1 irq after reset", irq, 0);
    rd(2'd1, d); chk("R12 count high byte", d, 0);
    rd(2'd3, d); chk("R12 unused address", d, 0);
    wr(2'd0, 8'h28);
    rd(2'd0, d); chk("R12 bit3 reads 0", d, 8'h20);
  endtask

  task automatic t_halt();
    logic [7:0] d;
    mod_val = 8'hFF;
    idle(20);
    rd(2'd2, d); chk("R2 halted count frozen", d, 0);
    wr(2'd0, 8'h00);
    idle(9);
    wr(2'd0, 8'h20);
    rd(2'd2, d); chk("R2 count after 10 running edges", d, 10);
    idle(10);
    rd(2'd2, d); chk("R2 count held while halted", d, 10);
  endtask

  task automatic t_presc();
    logic [7:0] d;
    mod_val = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      run_from_zero(3'(k), 4 * (1 << k) - 1);
      rd(2'd2, d); chk($sformatf("R3 sel=%0d just before 4th step", k), d, 3);
      run_from_zero(3'(k), 4 * (1 << k));
      rd(2'd2, d); chk($sformatf("R3 sel=%0d at 4th step", k), d, 4);
    end
  endtask

  task automatic t_wrap_and_clear();
    logic [7:0] d;
    mod_val = 8'd5;
    run_from_zero(3'd0, 5);
    rd(2'd2, d); chk("R4 count at modulo", d, 5);
    rd(2'd0, d); chk("R4 no flag before wrap", d, 8'h20);
    run_from_zero(3'd0, 6);
    rd(2'd2, d); chk("R4 count wrapped to 0", d, 0);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R6 write 0 without read keeps flag", d, 8'hA0);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R5 read then write 0 clears flag", d, 8'h20);
  endtask

  task automatic t_cancel();
    logic [7:0] d;
    mod_val = 8'd3;
    wr(2'd0, 8'h30);
    wr(2'd0, 8'h00);
    idle(8);
    rd(2'd0, d); chk("R7 flag set by running wraps", d[7], 1);
    idle(5);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R7 wrap between read and write keeps flag", d, 8'hA0);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R5 clear after fresh arming read", d, 8'h20);
  endtask

  task automatic t_flag_one();
    logic [7:0] d;
    wr(2'd0, 8'hA0);
    rd(2'd0, d); chk("R8 writing 1 to flag has no effect", d, 8'h20);
  endtask

  task automatic t_clear_bit();
    logic [7:0] d;
    mod_val = 8'd3;
    wr(2'd0, 8'h72);
    rd(2'd0, d); chk("R9 clear bit reads 0, fields kept", d, 8'h62);
    rd(2'd2, d); chk("R9 count zeroed", d, 0);
    idle(10);
    rd(2'd2, d); chk("R10 halt plus clear holds 0", d, 0);
    wr(2'd0, 8'h42);
    idle(5);
    wr(2'd0, 8'h52);
    idle(6);
    wr(2'd0, 8'h62);
    rd(2'd2, d); chk("R9 prescaler restarted by clear", d, 1);
    chk("R11 irq low while flag 0", irq, 0);
  endtask

  task automatic t_irq();
    wr(2'd0, 8'h70);
    mod_val = 8'd0;
    wr(2'd0, 8'h40);
    chk("R11 irq low before wrap", irq, 0);
    idle(1);
    chk("R11 irq lags flag by one cycle", irq, 0);
    idle(1);
    chk("R11 irq raised", irq, 1);
    wr(2'd0, 8'h60);
    wr(2'd0, 8'h20);
    chk("R11 irq still high the cycle enable drops", irq, 1);
    idle(1);
    chk("R11 irq low after enable cleared", irq, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_presc();
    t_wrap_and_clear();
    t_cancel();
    t_flag_one();
    t_clear_bit();
    t_irq();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule